// File: doc/BRIEF.md
# I2C Target Pin-Level Transaction Decoder

This block sits on the target side of a two-wire serial bus. It watches the clock and data lines, which arrive asynchronously, and reduces the pin activity to byte-level transactions on a small downstream interface. That interface carries a transfer-open pulse with a 7-bit address and a direction flag, a pulse for each written byte, a read request that takes a returned byte, a notice that the controller refused a read byte, and a transfer-close pulse. The block answers on one open-drain style data output.

The decoder accepts every address without matching. Each protocol phase advances on a rising clock edge. A driven data bit or acknowledge is presented from that rising edge and released on the following falling edge. In a read, the byte is fetched from downstream at the first bit of that byte. The block does not filter addresses, stretch the clock, decode 10-bit addresses or filter glitches.

Top module: `i2ct_xact_decoder`

## Requirements
- R1: After reset the remembered data and clock levels and the driven data level are all 1, the decoder is idle with no address captured, sda_o is 1 and no downstream pulse is raised.
- R2: A falling data line while the clock is high is a START. It clears any captured address and begins a new address byte. This applies in every state, so a repeated START works even from the refused-read stall.
- R3: A rising data line while the clock is high is a STOP. It returns the decoder to idle and raises xfer_end_o for one cycle, but only if an address byte was captured since the last START.
- R4: A change of the data line while the clock is low does not alter the protocol state. A pin that keeps its level causes no event.
- R5: In a write byte, each rising clock edge shifts the data level into the byte, MSB first. On the ninth rising edge after START, the byte is taken as the address: bits 7:1 go to xfer_addr_o, bit 0 goes to xfer_rd_o (1 = read), xfer_start_o pulses and sda_o is driven low as the acknowledge.
- R6: After a write-direction address, each later byte gets the same treatment on its ninth rising edge: wr_valid_o pulses with the byte on wr_data_o and sda_o is driven low as the acknowledge.
- R7: After a read-direction address, rd_req_o pulses on the first rising edge of each read byte and rd_data_i is loaded in that same cycle. The byte is then presented MSB first, one bit per rising edge, and released to 1 on each falling edge.
- R8: The data level sampled on the ninth rising edge of a read byte is the controller's acknowledge. A 0 starts another read byte. A 1 pulses nack_o and enters a stall in which clocks are ignored and sda_o stays released until a START or STOP.
- R9: sda_o equals the decoder's drive level ANDed with the last observed data-line level.
- R10: Both pins pass through SYNC_STAGES flip-flops before edge detection. If both pins change in the same cycle, the data change is evaluated first, against the old clock level.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| sda_o | output | 1 | Open-drain data drive (0 pulls low) |
| xfer_start_o | output | 1 | One-cycle pulse when the address byte is acknowledged |
| xfer_addr_o | output | 7 | Target address, valid with xfer_start_o |
| xfer_rd_o | output | 1 | Direction, valid with xfer_start_o (1 = read) |
| wr_valid_o | output | 1 | One-cycle pulse for a received write byte |
| wr_data_o | output | 8 | Write byte, valid with wr_valid_o |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Read byte, sampled in the rd_req_o cycle |
| nack_o | output | 1 | One-cycle pulse when the controller refuses a read byte |
| xfer_end_o | output | 1 | One-cycle pulse on STOP after a captured address |

## Verification
Most internal faults show up within one bus bit. A bit counter or shift-direction error puts the acknowledge low on the wrong rising edge, or corrupts the byte on xfer_addr_o or wr_data_o. A lost address-captured flag shows up only at the next STOP, as a missing or extra xfer_end_o. A stall state that fails to release, or that keeps counting, shows up as sda_o low or an extra rd_req_o on the next clock pulse. The bench therefore checks sda_o at each rising and falling edge and compares the pulse counts after every transaction.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WBIT,
    PH_WACK,
    PH_RBIT,
    PH_RACK,
    PH_STALL
  } phase_e;

  // shift one received bit into the low end of a byte
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] b, input logic d);
    return {b[BYTE_W-2:0], d};
  endfunction

  // true when the bit counter points at the final bit of a byte
  function automatic logic is_last_bit(input logic [CNT_W-1:0] c);
    return c == CNT_W'(BYTE_W - 1);
  endfunction
endpackage

// File: rtl/i2ct_pin_sync.sv
module i2ct_pin_sync #(
  parameter int unsigned PINS   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] now_o,
  output logic [PINS-1:0] prev_o
);
  logic [PINS-1:0] stg [STAGES];
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= pin_i;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign now_o  = stg[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_now,
  input  logic              sda_prev,
  input  logic              scl_now,
  input  logic              scl_prev,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              nack_o,
  output logic              end_o,
  output logic              drive_o
);
  phase_e            ph_q, ph_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] buf_q, buf_n, rbyte;
  logic              av_q, av_n, dir_q, dir_n, drv_q, drv_n;

  // named bus events
  logic sda_chg, scl_chg, start_ev, stop_ev, scl_rise, scl_fall;
  assign sda_chg  = sda_now != sda_prev;
  assign scl_chg  = scl_now != scl_prev;
  assign start_ev = sda_chg && scl_prev && !sda_now;
  assign stop_ev  = sda_chg && scl_prev && sda_now;
  assign scl_rise = scl_chg && scl_now;
  assign scl_fall = scl_chg && !scl_now;

  always_comb begin
    ph_n = ph_q; cnt_n = cnt_q; buf_n = buf_q;
    av_n = av_q; dir_n = dir_q; drv_n = drv_q;
    start_o = 1'b0; wr_valid_o = 1'b0; rd_req_o = 1'b0;
    nack_o = 1'b0; end_o = 1'b0; rbyte = buf_q;
    // data line first, judged against the old clock level
    if (start_ev) begin
      ph_n = PH_WBIT; cnt_n = '0; av_n = 1'b0; drv_n = 1'b1;
    end else if (stop_ev) begin
      end_o = av_q; ph_n = PH_IDLE; av_n = 1'b0; drv_n = 1'b1;
    end
    if (scl_fall) drv_n = 1'b1;
    if (scl_rise) begin
      drv_n = 1'b1;
      case (ph_n)
        PH_WBIT: begin
          buf_n = shift_in(buf_n, sda_now);
          if (is_last_bit(cnt_n)) ph_n = PH_WACK;
          cnt_n = cnt_n + CNT_W'(1);
        end
        PH_WACK: begin
          if (!av_n) begin
            start_o = 1'b1; av_n = 1'b1; dir_n = buf_n[0];
          end else begin
            wr_valid_o = 1'b1;
          end
          ph_n = dir_n ? PH_RBIT : PH_WBIT;
          cnt_n = '0; drv_n = 1'b0;
        end
        PH_RBIT: begin
          if (cnt_n == '0) begin
            rd_req_o = 1'b1; rbyte = rd_data_i;
          end else begin
            rbyte = buf_n;
          end
          drv_n = rbyte[BYTE_W-1];
          buf_n = {rbyte[BYTE_W-2:0], 1'b0};
          if (is_last_bit(cnt_n)) ph_n = PH_RACK;
          cnt_n = cnt_n + CNT_W'(1);
        end
        PH_RACK: begin
          if (sda_now) begin
            nack_o = 1'b1; ph_n = PH_STALL;
          end else begin
            ph_n = PH_RBIT; cnt_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; buf_q <= '0;
      av_q <= 1'b0; dir_q <= 1'b0; drv_q <= 1'b1;
    end else begin
      ph_q <= ph_n; cnt_q <= cnt_n; buf_q <= buf_n;
      av_q <= av_n; dir_q <= dir_n; drv_q <= drv_n;
    end
  end

  assign addr_o    = buf_n[BYTE_W-1:1];
  assign rd_o      = buf_n[0];
  assign wr_data_o = buf_n;
  assign drive_o   = drv_q;

  // R3
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (ph_q == PH_IDLE && !av_q));
  // R5
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (av_q && !drv_q));
  // R7
  rd_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> (drv_q == $past(rd_data_i[BYTE_W-1])));
  // R8
  nack_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |=> (ph_q == PH_STALL));
  // R8
  stall_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STALL) |-> drv_q);
  // R4
  low_clk_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_chg && !scl_prev && !scl_chg) |=> $stable(ph_q));
endmodule

// File: rtl/i2ct_xact_decoder.sv
module i2ct_xact_decoder
  import i2ct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              xfer_start_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_rd_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              nack_o,
  output logic              xfer_end_o
);
  logic [1:0] pin_now, pin_prev;
  logic       drive;

  i2ct_pin_sync #(.PINS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({scl_i, sda_i}),
    .now_o  (pin_now),
    .prev_o (pin_prev)
  );

  i2ct_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_now    (pin_now[0]),
    .sda_prev   (pin_prev[0]),
    .scl_now    (pin_now[1]),
    .scl_prev   (pin_prev[1]),
    .rd_data_i  (rd_data_i),
    .start_o    (xfer_start_o),
    .addr_o     (xfer_addr_o),
    .rd_o       (xfer_rd_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o),
    .nack_o     (nack_o),
    .end_o      (xfer_end_o),
    .drive_o    (drive)
  );

  // wired-AND with the remembered data level
  assign sda_o = drive & pin_prev[0];

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_start_o, wr_valid_o, rd_req_o, nack_o, xfer_end_o}));
  // R8
  stall_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |=> !rd_req_o);
endmodule

// File: tb/tb_i2ct_xact_decoder.sv
module tb_i2ct_xact_decoder;
  logic clk = 1'b0, rst_n = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
  logic sda_o, xfer_start_o, xfer_rd_o, wr_valid_o, rd_req_o, nack_o, xfer_end_o;
  logic [6:0] xfer_addr_o;
  logic [7:0] wr_data_o, rd_src;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_wr = 0, n_req = 0, n_nack = 0, n_end = 0;
  logic [6:0] last_addr;
  logic last_rd;
  logic [7:0] last_wr;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  i2ct_xact_decoder dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o),
    .xfer_start_o(xfer_start_o), .xfer_addr_o(xfer_addr_o), .xfer_rd_o(xfer_rd_o),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .rd_req_o(rd_req_o),
    .rd_data_i(rd_src), .nack_o(nack_o), .xfer_end_o(xfer_end_o)
  );

  // downstream model: records pulses, serves read bytes stepping by 8'h37
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_src <= 8'hA5;
    else begin
      if (xfer_start_o) begin n_start <= n_start + 1; last_addr <= xfer_addr_o; last_rd <= xfer_rd_o; end
      if (wr_valid_o) begin n_wr <= n_wr + 1; last_wr <= wr_data_o; end
      if (rd_req_o) begin n_req <= n_req + 1; rd_src <= rd_src + 8'h37; end
      if (nack_o) n_nack <= n_nack + 1;
      if (xfer_end_o) n_end <= n_end + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic d);
    scl_i = c; sda_i = d;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_cond();
    pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
  endtask

  task automatic stop_cond();
    pins(0, 0); pins(1, 0); pins(1, 1);
  endtask

  task automatic wbyte(input logic [7:0] v, input logic wiggle, input string req);
    for (int i = 7; i >= 0; i--) begin
      pins(0, v[i]); pins(1, v[i]); pins(0, v[i]);
      if (wiggle) begin pins(0, ~v[i]); pins(0, v[i]); end
    end
    pins(0, 1); pins(1, 1);
    chk({req, " ack low"}, sda_o, 1'b0);
    pins(0, 1);
    chk({req, " ack released"}, sda_o, 1'b1);
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] v);
    v = '0;
    for (int i = 7; i >= 0; i--) begin
      pins(0, 1); pins(1, 1);
      v = {v[6:0], sda_o};
      pins(0, 1);
      if (i == 0) chk("R7 released on falling edge", sda_o, 1'b1);
    end
    pins(0, ack); pins(1, ack); pins(0, ack);
  endtask

  task automatic t_reset();
    chk("R1 sda_o", sda_o, 1'b1);
    chk("R1 no pulses", n_start + n_wr + n_req + n_nack + n_end, 0);
  endtask

  task automatic t_write();
    start_cond();
    wbyte({7'h5A, 1'b0}, 1'b0, "R5");
    chk("R5 start count", n_start, 1);
    chk("R5 addr", last_addr, 7'h5A);
    chk("R5 dir write", last_rd, 1'b0);
    wbyte(8'hC3, 1'b0, "R6");
    chk("R6 wr count", n_wr, 1);
    chk("R6 wr data", last_wr, 8'hC3);
    stop_cond();
    chk("R3 end after addr", n_end, 1);
  endtask

  task automatic t_read();
    logic [7:0] got, exp_b;
    exp_b = rd_src;
    start_cond();
    wbyte({7'h27, 1'b1}, 1'b0, "R5 read addr");
    chk("R5 dir read", last_rd, 1'b1);
    pins(0, 1); pins(1, 1);
    chk("R7 request at first bit", n_req, 1);
    chk("R7 msb driven", sda_o, exp_b[7]);
    pins(0, 1);
    got = {7'b0, exp_b[7]};
    for (int i = 6; i >= 0; i--) begin
      pins(1, 1); got = {got[6:0], sda_o}; pins(0, 1);
    end
    pins(0, 0); pins(1, 0); pins(0, 0);
    chk("R7 read byte 1", got, exp_b);
    exp_b = exp_b + 8'h37;
    rbyte(1'b1, got);
    chk("R8 ack continues, byte 2", got, exp_b);
    chk("R8 nack pulse", n_nack, 1);
    pins(0, 1); pins(1, 1);
    chk("R8 stall released", sda_o, 1'b1);
    pins(0, 1); pins(1, 1); pins(0, 1);
    chk("R8 stall no request", n_req, 2);
    // repeated START out of the stall
    start_cond();
    wbyte({7'h31, 1'b0}, 1'b0, "R2");
    chk("R2 restart from stall", n_start, 3);
    chk("R2 restart addr", last_addr, 7'h31);
    chk("R2 no end on restart", n_end, 1);
    stop_cond();
    chk("R3 end after read", n_end, 2);
  endtask

  task automatic t_stop_no_addr();
    start_cond();
    pins(0, 1); pins(1, 1); pins(0, 1);
    stop_cond();
    chk("R3 no end without addr", n_end, 2);
  endtask

  task automatic t_ignore();
    pins(0, 1); pins(0, 0); pins(0, 1); pins(0, 0); pins(0, 1);
    pins(1, 1); pins(0, 1);
    chk("R4 no start from low-clock toggles", n_start, 3);
    start_cond();
    wbyte(8'h9C, 1'b1, "R4");
    chk("R4 addr despite wiggles", last_addr, 7'h4E);
    wbyte(8'h3E, 1'b1, "R4");
    chk("R4 data despite wiggles", last_wr, 8'h3E);
    stop_cond();
  endtask

  task automatic t_wired_and();
    pins(0, 1);
    chk("R9 released high", sda_o, 1'b1);
    pins(0, 0);
    chk("R9 follows low line", sda_o, 1'b0);
    pins(0, 1);
    chk("R9 back high", sda_o, 1'b1);
  endtask

  task automatic t_same_cycle();
    pins(1, 1);
    pins(0, 0);
    wbyte({7'h10, 1'b0}, 1'b0, "R10");
    chk("R10 sda first gives START", n_start, 5);
    chk("R10 addr", last_addr, 7'h10);
    stop_cond();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_stop_no_addr();
    t_ignore();
    t_wired_and();
    t_same_cycle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule